// File: doc/BRIEF.md
# Multiprocessor Serial Port with Address Filtering

This block is a full-duplex asynchronous serial port that sits on a byte-wide register bus. It sends and receives frames of eight data bits, or nine when the 9-bit mode is on. The bit clock is a tick input at sixteen times the bit rate. A control bit picks this tick from either a timer overflow or a shared baud generator. The transmitter and the receiver run at the same time and do not wait on each other. The receiver has a holding register apart from its shift register, so it can shift in a new frame while software has not yet read the last one.

In multiprocessor mode, a frame whose ninth bit is 1 is an address frame. The hardware compares it with a programmable address under a programmable mask and keeps it only on a match. Data frames, whose ninth bit is 0, are kept only while the most recent address frame matched. Frames that are dropped never raise the receive flag, so software sees only the traffic addressed to it.

The transmitter state machine has five states: TX_IDLE, TX_START, TX_DATA, TX_NINTH and TX_STOP.
- TX_IDLE moves to TX_START on a write to the data register.
- Each of the other states ends after sixteen ticks.
- TX_START moves to TX_DATA.
- After the last data bit, TX_DATA moves to TX_NINTH in 9-bit mode, otherwise to TX_STOP.
- TX_NINTH moves to TX_STOP.
- TX_STOP returns to TX_IDLE.

The receiver state machine has the matching states RX_IDLE, RX_START, RX_DATA, RX_NINTH and RX_STOP.
- RX_IDLE moves to RX_START when a tick finds the line low.
- At the end of the start bit, RX_START returns to RX_IDLE if the vote was high (a false start). Otherwise it moves to RX_DATA.
- The remaining transitions follow the transmitter.

Top module: `mpuart`

## Requirements
- R1: After reset the control, address and mask registers read 0x00, txd is high and irq is low.
- R2: The register map is: offset 0 data, 1 control, 2 address, 3 mask. The address and mask registers read back what was written. Writing offset 0 while the transmitter is idle sends a frame on txd: a low start bit, the eight data bits LSB first, then control bit 3 as the ninth bit in 9-bit mode, then a high stop bit. Each bit lasts 16 ticks. A data write made while a frame is in progress is ignored.
- R3: The receiver takes 16 ticks per bit and decides each bit by a majority of the samples at ticks 7, 8 and 9 of the bit. It stores the byte (LSB first) in a holding register read at offset 0 and sets control bit 1. In 9-bit mode the received ninth bit appears in control bit 2; in 8-bit mode that bit reads 0.
- R4: A start bit whose mid-bit vote is high is dropped. No flag changes, and the receiver accepts the next proper frame.
- R5: A frame whose stop bit votes low sets control bit 7. It neither loads the holding register nor sets control bit 1. Bit 7 stays set through later good frames until software clears it.
- R6: Control bits 0 (transmit done), 1 (receive done) and 7 (framing error) are set only by hardware. Writing 0 to a flag clears it; writing 1 leaves it unchanged. irq equals bit 0 OR bit 1. Bit 0 is set when a stop bit has been sent in full.
- R7: Reception continues while control bit 1 is set. A frame that completes while bit 1 is still set is discarded, and the holding register keeps its value.
- R8: Transmission and reception proceed at the same time without disturbing each other.
- R9: Multiprocessor filtering is active only when control bit 5 and control bit 6 (9-bit mode) are both 1. With bit 5 set in 8-bit mode, every frame is kept. In filtering, an address frame (ninth bit 1) is kept exactly when ((byte XOR address) AND mask) == 0, so a mask of 0x00 matches any byte.
- R10: In filtering, a data frame (ninth bit 0) is kept only if the most recent address frame matched. An address frame that does not match cancels acceptance.
- R11: Control bit 4 selects the bit tick: 0 takes tick_tmr, 1 takes tick_gen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tick_tmr | input | 1 | 16x bit tick from a timer overflow |
| tick_gen | input | 1 | 16x bit tick from the shared baud generator |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Transmit-done OR receive-done |

## Verification
A table of received frames drives the filter through a matching address, a data frame after a match, a mismatching address followed by a data frame, a partial mask and an all-zero mask. This separates exact comparison from masked comparison and shows that acceptance is held in state between frames. The same table covers 8-bit frames, 9-bit frames and the multiprocessor bit set in 8-bit mode, which tells the ninth-bit path apart from the filter enable. Directed frames cover:
- a bad stop bit, and the framing flag staying set through a later good frame;
- a short low glitch (false start);
- a read that overlaps the next reception, against an unread byte being overrun;
- a transmission decoded from txd while a reception runs at the same time;
- the timer tick source at a different rate.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_NINTH, TX_STOP} tx_state_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_NINTH, RX_STOP} rx_state_t;

    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_ADDR = 2'd2;
    localparam logic [1:0] REG_MASK = 2'd3;

    localparam int CB_TXDONE = 0;
    localparam int CB_RXDONE = 1;
    localparam int CB_RXB9   = 2;
    localparam int CB_TXB9   = 3;
    localparam int CB_CLKSEL = 4;
    localparam int CB_MPEN   = 5;
    localparam int CB_NINE   = 6;
    localparam int CB_FERR   = 7;
endpackage

// File: rtl/mpuart_tx.sv
module mpuart_tx
    import mpuart_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [DW-1:0] din,
    input  logic          b9_in,
    input  logic          nine,
    output logic          txd,
    output logic          busy,
    output logic          done
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DW);

    tx_state_t     state, nxt;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bidx;
    logic [DW-1:0] shreg;
    logic          b9;
    logic          bit_end;

    assign bit_end = tick && (cnt == CW'(OVS-1));

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (start) nxt = TX_START;
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && bidx == BW'(DW-1)) nxt = nine ? TX_NINTH : TX_STOP;
            TX_NINTH: if (bit_end) nxt = TX_STOP;
            TX_STOP:  if (bit_end) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            shreg <= '0;
            b9    <= 1'b0;
        end else begin
            state <= nxt;
            if (state == TX_IDLE) begin
                cnt  <= '0;
                bidx <= '0;
                if (start) begin
                    shreg <= din;
                    b9    <= b9_in;
                end
            end else begin
                if (tick) cnt <= (cnt == CW'(OVS-1)) ? '0 : cnt + 1'b1;
                if (state == TX_DATA && bit_end) begin
                    bidx  <= bidx + 1'b1;
                    shreg <= shreg >> 1;
                end
            end
        end
    end

    always_comb begin
        txd  = 1'b1;
        busy = (state != TX_IDLE);
        done = (state == TX_STOP) && bit_end;
        unique case (state)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_NINTH: txd = b9;
            TX_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && start) |=> !txd); // R2
    AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R2
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int DW   = 8,
    parameter int OVS  = 16,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          nine,
    output logic          frame_done,
    output logic          frame_stop_ok,
    output logic [DW-1:0] frame_byte,
    output logic          frame_b9
);
    localparam int CW  = $clog2(OVS);
    localparam int BW  = $clog2(DW);
    localparam int MID = OVS / 2;

    rx_state_t       state, nxt;
    logic [SYNC-1:0] sync_q;
    logic            line;
    logic [CW-1:0]   cnt;
    logic [BW-1:0]   bidx;
    logic [DW-1:0]   shreg;
    logic            b9;
    logic [2:0]      votes;
    logic            maj;
    logic            bit_end;
    logic            in_window;

    assign line      = sync_q[SYNC-1];
    assign bit_end   = tick && (cnt == CW'(OVS-1));
    assign in_window = (cnt >= CW'(MID-1)) && (cnt <= CW'(MID+1));
    assign maj       = (votes[0] & votes[1]) | (votes[0] & votes[2]) | (votes[1] & votes[2]);

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick && !line) nxt = RX_START;
            RX_START: if (bit_end) nxt = maj ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && bidx == BW'(DW-1)) nxt = nine ? RX_NINTH : RX_STOP;
            RX_NINTH: if (bit_end) nxt = RX_STOP;
            RX_STOP:  if (bit_end) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= RX_IDLE;
            sync_q <= '1;
            cnt    <= '0;
            bidx   <= '0;
            shreg  <= '0;
            b9     <= 1'b0;
            votes  <= '1;
        end else begin
            state  <= nxt;
            sync_q <= {sync_q[SYNC-2:0], rxd};
            if (state == RX_IDLE) begin
                bidx <= '0;
                cnt  <= (tick && !line) ? CW'(1) : '0;
                if (tick && !line) b9 <= 1'b0;
            end else if (tick) begin
                cnt <= (cnt == CW'(OVS-1)) ? '0 : cnt + 1'b1;
                if (in_window) votes <= {votes[1:0], line};
                if (state == RX_DATA && bit_end) begin
                    shreg <= {maj, shreg[DW-1:1]};
                    bidx  <= bidx + 1'b1;
                end
                if (state == RX_NINTH && bit_end) b9 <= maj;
            end
        end
    end

    always_comb begin
        frame_done    = (state == RX_STOP) && bit_end;
        frame_stop_ok = maj;
        frame_byte    = shreg;
        frame_b9      = b9;
    end

    AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R3
endmodule

// File: rtl/mpuart_filter.sv
module mpuart_filter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mp_active,
    input  logic          frame_valid,
    input  logic          frame_b9,
    input  logic [DW-1:0] frame_byte,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] mask,
    output logic          accept
);
    logic [DW-1:0] bit_ok;
    logic          match;
    logic          addressed;

    for (genvar i = 0; i < DW; i++) begin : g_cmp
        assign bit_ok[i] = !mask[i] || (frame_byte[i] == addr[i]);
    end
    assign match = &bit_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       addressed <= 1'b0;
        else if (!mp_active)              addressed <= 1'b0;
        else if (frame_valid && frame_b9) addressed <= match;
    end

    assign accept = !mp_active || (frame_b9 ? match : addressed);

    AST_ADDR_MISS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_active && frame_valid && frame_b9 && !match) |=> !addressed); // R10
endmodule

// File: rtl/mpuart.sv
module mpuart
    import mpuart_pkg::*;
#(
    parameter int DW   = 8,
    parameter int OVS  = 16,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          tick_tmr,
    input  logic          tick_gen,
    input  logic          rxd,
    output logic          txd,
    output logic          irq
);
    logic          tx_done_q, rx_done_q, rx_b9_q, tx_b9_q;
    logic          clk_sel_q, mp_en_q, nine_q, ferr_q;
    logic [DW-1:0] addr_q, mask_q, hold_q;
    logic          tick, wr_ctrl, wr_data;
    logic          tx_busy, tx_fin, tx_start;
    logic          frame_done, frame_stop_ok, frame_b9;
    logic [DW-1:0] frame_byte;
    logic          accept, rx_load;
    logic [7:0]    ctrl_view;
    logic          unused_wbit;

    assign tick        = clk_sel_q ? tick_gen : tick_tmr;
    assign wr_ctrl     = reg_wr && (reg_addr == REG_CTRL);
    assign wr_data     = reg_wr && (reg_addr == REG_DATA);
    assign tx_start    = wr_data && !tx_busy;
    assign unused_wbit = reg_wdata[CB_RXB9];

    mpuart_tx #(.DW(DW), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start),
        .din(reg_wdata), .b9_in(tx_b9_q), .nine(nine_q),
        .txd(txd), .busy(tx_busy), .done(tx_fin)
    );

    mpuart_rx #(.DW(DW), .OVS(OVS), .SYNC(SYNC)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine(nine_q),
        .frame_done(frame_done), .frame_stop_ok(frame_stop_ok),
        .frame_byte(frame_byte), .frame_b9(frame_b9)
    );

    mpuart_filter #(.DW(DW)) u_filt (
        .clk(clk), .rst_n(rst_n), .mp_active(mp_en_q && nine_q),
        .frame_valid(frame_done && frame_stop_ok), .frame_b9(frame_b9),
        .frame_byte(frame_byte), .addr(addr_q), .mask(mask_q), .accept(accept)
    );

    assign rx_load = frame_done && frame_stop_ok && accept && !rx_done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_done_q <= 1'b0;
            rx_done_q <= 1'b0;
            rx_b9_q   <= 1'b0;
            tx_b9_q   <= 1'b0;
            clk_sel_q <= 1'b0;
            mp_en_q   <= 1'b0;
            nine_q    <= 1'b0;
            ferr_q    <= 1'b0;
            addr_q    <= '0;
            mask_q    <= '0;
            hold_q    <= '0;
        end else begin
            if (tx_fin)                                 tx_done_q <= 1'b1;
            else if (wr_ctrl && !reg_wdata[CB_TXDONE])  tx_done_q <= 1'b0;
            if (rx_load)                                rx_done_q <= 1'b1;
            else if (wr_ctrl && !reg_wdata[CB_RXDONE])  rx_done_q <= 1'b0;
            if (frame_done && !frame_stop_ok)           ferr_q <= 1'b1;
            else if (wr_ctrl && !reg_wdata[CB_FERR])    ferr_q <= 1'b0;
            if (rx_load) begin
                hold_q  <= frame_byte;
                rx_b9_q <= frame_b9;
            end
            if (wr_ctrl) begin
                tx_b9_q   <= reg_wdata[CB_TXB9];
                clk_sel_q <= reg_wdata[CB_CLKSEL];
                mp_en_q   <= reg_wdata[CB_MPEN];
                nine_q    <= reg_wdata[CB_NINE];
            end
            if (reg_wr && reg_addr == REG_ADDR) addr_q <= reg_wdata;
            if (reg_wr && reg_addr == REG_MASK) mask_q <= reg_wdata;
        end
    end

    always_comb begin
        ctrl_view = {ferr_q, nine_q, mp_en_q, clk_sel_q, tx_b9_q, rx_b9_q, rx_done_q, tx_done_q};
        unique case (reg_addr)
            REG_DATA: reg_rdata = hold_q;
            REG_CTRL: reg_rdata = DW'(ctrl_view);
            REG_ADDR: reg_rdata = addr_q;
            REG_MASK: reg_rdata = mask_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = tx_done_q | rx_done_q;

    AST_TXDONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done_q && !(wr_ctrl && !reg_wdata[CB_TXDONE])) |=> tx_done_q); // R6
    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr_q && !(wr_ctrl && !reg_wdata[CB_FERR])) |=> ferr_q); // R5
    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_q && !(wr_ctrl && !reg_wdata[CB_RXDONE])) |=> $stable(hold_q)); // R7
    AST_ADDR_MATCH_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && mp_en_q && nine_q && frame_b9) |-> (((frame_byte ^ addr_q) & mask_q) == '0)); // R9
    AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd); // R2
endmodule

// File: tb/mpuart_test.sv
module mpuart_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tick_tmr = 1'b0, tick_gen = 1'b0;
    logic       rxd = 1'b1;
    logic       txd, irq;
    int         errors = 0, checks = 0;
    bit         finished = 0;

    mpuart uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_tmr(tick_tmr),
        .tick_gen(tick_gen), .rxd(rxd), .txd(txd), .irq(irq)
    );

    always #2 clk = ~clk;

    localparam int PGEN = 2;
    localparam int PTMR = 3;

    initial begin
        int gc = 0, tc = 0;
        forever begin
            @(negedge clk);
            gc = (gc + 1) % PGEN;
            tc = (tc + 1) % PTMR;
            tick_gen = (gc == 0);
            tick_tmr = (tc == 0);
        end
    end

    // {nine, mp, addr, mask, data, b9, expect_kept}
    localparam logic [27:0] VEC [12] = '{
        {1'b0, 1'b0, 8'h00, 8'h00, 8'hA5, 1'b0, 1'b1},
        {1'b1, 1'b0, 8'h00, 8'h00, 8'h3C, 1'b1, 1'b1},
        {1'b0, 1'b1, 8'h12, 8'hFF, 8'h99, 1'b0, 1'b1},
        {1'b1, 1'b1, 8'h12, 8'hFF, 8'h12, 1'b1, 1'b1},
        {1'b1, 1'b1, 8'h12, 8'hFF, 8'h77, 1'b0, 1'b1},
        {1'b1, 1'b1, 8'h12, 8'hFF, 8'h13, 1'b1, 1'b0},
        {1'b1, 1'b1, 8'h12, 8'hFF, 8'h55, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'h12, 8'hF0, 8'h1F, 1'b1, 1'b1},
        {1'b1, 1'b1, 8'h12, 8'hF0, 8'h66, 1'b0, 1'b1},
        {1'b1, 1'b1, 8'h12, 8'h00, 8'hC3, 1'b1, 1'b1},
        {1'b1, 1'b1, 8'h12, 8'h0F, 8'h22, 1'b1, 1'b1},
        {1'b1, 1'b1, 8'h12, 8'h0F, 8'h25, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input logic [7:0] b, input logic b9, input logic stp,
                        input logic nine, input int per);
        @(negedge clk);
        rxd = 1'b0;
        repeat (16*per) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (16*per) @(negedge clk);
        end
        if (nine) begin
            rxd = b9;
            repeat (16*per) @(negedge clk);
        end
        rxd = stp;
        repeat (16*per) @(negedge clk);
        rxd = 1'b1;
    endtask

    task automatic capture(output logic [7:0] b, output logic b9, output logic stp,
                           input logic nine, input int per);
        @(negedge txd);
        repeat (8*per) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (16*per) @(negedge clk);
            b[i] = txd;
        end
        b9 = 1'b0;
        if (nine) begin
            repeat (16*per) @(negedge clk);
            b9 = txd;
        end
        repeat (16*per) @(negedge clk);
        stp = txd;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, last, tb, rb;
        logic       tb9, tstp;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(2'd1, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd2, v); chk("R1 addr", v, 8'h00);
        rd(2'd3, v); chk("R1 mask", v, 8'h00);
        chk("R1 txd", txd, 1'b1);
        chk("R1 irq", irq, 1'b0);

        // R2 register readback
        wr(2'd2, 8'h5A); wr(2'd3, 8'hA5);
        rd(2'd2, v); chk("R2 addr readback", v, 8'h5A);
        rd(2'd3, v); chk("R2 mask readback", v, 8'hA5);

        // Table walk: R3 R9 R10 receive filtering
        last = 8'h00;
        for (int k = 0; k < 12; k++) begin
            logic [27:0] e;
            e = VEC[k];
            wr(2'd1, {1'b0, e[27], e[26], 1'b1, 4'b0000});
            wr(2'd2, e[25:18]);
            wr(2'd3, e[17:10]);
            send(e[9:2], e[1], 1'b1, e[27], PGEN);
            repeat (40) @(negedge clk);
            rd(2'd1, v);
            chk($sformatf("R9 R10 vec%0d kept", k), v[1], e[0]);
            rd(2'd0, rb);
            if (e[0]) begin
                chk($sformatf("R3 vec%0d data", k), rb, e[9:2]);
                chk($sformatf("R3 vec%0d ninth", k), v[2], e[27] & e[1]);
                last = e[9:2];
            end else begin
                chk($sformatf("R10 vec%0d hold unchanged", k), rb, last);
            end
        end

        // R2 R8 transmit while receiving; R2 busy write ignored
        wr(2'd1, 8'h58);
        fork
            capture(tb, tb9, tstp, 1'b1, PGEN);
            begin wr(2'd0, 8'hC6); repeat (60) @(negedge clk); wr(2'd0, 8'h00); end
            send(8'h5A, 1'b0, 1'b1, 1'b1, PGEN);
        join
        repeat (40) @(negedge clk);
        chk("R2 tx byte", tb, 8'hC6);
        chk("R2 tx ninth", tb9, 1'b1);
        chk("R2 tx stop", tstp, 1'b1);
        rd(2'd1, v);
        chk("R6 tx done", v[0], 1'b1);
        chk("R8 rx done during tx", v[1], 1'b1);
        chk("R6 irq", irq, 1'b1);
        rd(2'd0, v); chk("R8 rx data during tx", v, 8'h5A);

        // R4 false start
        wr(2'd1, 8'h10);
        @(negedge clk); rxd = 1'b0;
        repeat (3*PGEN) @(negedge clk); rxd = 1'b1;
        repeat (100) @(negedge clk);
        rd(2'd1, v); chk("R4 false start no flag", v[1], 1'b0);
        send(8'h3E, 1'b0, 1'b1, 1'b0, PGEN);
        repeat (40) @(negedge clk);
        rd(2'd0, v); chk("R4 recovers after glitch", v, 8'h3E);

        // R5 framing error, sticky
        wr(2'd1, 8'h10);
        send(8'h81, 1'b0, 1'b0, 1'b0, PGEN);
        repeat (100) @(negedge clk);
        rd(2'd1, v);
        chk("R5 ferr set", v[7], 1'b1);
        chk("R5 no rx done", v[1], 1'b0);
        rd(2'd0, v); chk("R5 hold unchanged", v, 8'h3E);
        send(8'h4D, 1'b0, 1'b1, 1'b0, PGEN);
        repeat (40) @(negedge clk);
        rd(2'd1, v);
        chk("R5 ferr sticky", v[7], 1'b1);
        chk("R5 good frame after", v[1], 1'b1);
        wr(2'd1, 8'h12);
        rd(2'd1, v);
        chk("R6 ferr cleared by 0", v[7], 1'b0);
        chk("R6 rx done kept by 1", v[1], 1'b1);
        wr(2'd1, 8'h10);
        rd(2'd1, v); chk("R6 rx done cleared by 0", v[1], 1'b0);

        // R7 buffered receive and overrun
        send(8'h11, 1'b0, 1'b1, 1'b0, PGEN);
        repeat (40) @(negedge clk);
        fork
            send(8'h22, 1'b0, 1'b1, 1'b0, PGEN);
            begin
                logic [7:0] w;
                repeat (100) @(negedge clk);
                rd(2'd0, w); chk("R7 first byte during next", w, 8'h11);
                wr(2'd1, 8'h10);
            end
        join
        repeat (40) @(negedge clk);
        rd(2'd0, v); chk("R7 overlapped byte", v, 8'h22);
        send(8'h33, 1'b0, 1'b1, 1'b0, PGEN);
        repeat (40) @(negedge clk);
        rd(2'd0, v); chk("R7 overrun discarded", v, 8'h22);
        rd(2'd1, v); chk("R7 rx done still set", v[1], 1'b1);

        // R11 timer tick source
        wr(2'd1, 8'h00);
        send(8'h5C, 1'b0, 1'b1, 1'b0, PTMR);
        repeat (60) @(negedge clk);
        rd(2'd0, v); chk("R11 timer tick data", v, 8'h5C);
        rd(2'd1, v); chk("R11 timer tick done", v[1], 1'b1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule